// File: doc/BRIEF.md
# Interrupt Controller Base and Mode Register

This block holds the 64-bit base and mode control word of a per-processor interrupt controller. The controller can be in one of three operating modes: switched off, enabled in the classic (legacy) addressing mode, or enabled in the extended addressing mode with wide identifiers. Software changes the mode by writing the whole word. The block checks each write against a small graph of legal mode changes. An illegal write changes nothing and raises a one-cycle error pulse.

An accepted write always takes the base-address field from the written data. The bootstrap-processor flag keeps the value it had at reset. A write that switches the controller off also sends a one-cycle pulse to the priority core, which clears that core's software-enable bit. Whenever an accepted write leaves the controller in extended mode, the block derives a 32-bit logical identifier from the agent's initial physical identifier. Decoding of the memory region that the base address selects is done elsewhere.

Top module: `lic_mode_ctrl`

## Requirements
- R1: A write whose extended bit (data bit 10) is 1 while `ext_supported` is 0 is rejected.
- R2: A write with the extended bit at 1 and the enable bit (data bit 11) at 0 is rejected as an invalid state.
- R3: From the off mode (mode code 0), a write that requests enabled-extended is rejected. The legacy mode must be entered first.
- R4: From the extended mode (mode code 2), a write that requests enabled-legacy (enable 1, extended 0) is rejected.
- R5: An accepted write with the enable bit at 0 sets the mode to off. In the cycle after the write, `sw_en_clear` is 1 for exactly one cycle. This holds even when the controller is already off.
- R6: An accepted write that results in extended mode loads `ext_lid` as follows. Bits 31:16 take `init_id` bits 19:4. Bits 15:0 are one-hot, with the set bit at the index given by `init_id` bits 3:0. In any other case `ext_lid` keeps its value.
- R7: An accepted write loads `base_addr` from data bits 35:12. `bootstrap` never changes after reset, whatever is written in data bit 8.
- R8: A rejected write leaves `mode`, `base_addr`, `bootstrap` and `ext_lid` unchanged. In the cycle after the write, `wr_err` is 1 for exactly one cycle and `sw_en_clear` stays 0.
- R9: A synchronous reset sets the following state: mode legacy (code 1), `base_addr` 0x0FEE00, `bootstrap` 1, `ext_lid` 0, and both pulses 0.
- R10: These transitions are accepted: off to off, off to legacy, legacy to legacy, legacy to extended (when supported), and extended to extended. All outputs are registered and change in the cycle after the write is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_data | input | 64 | Write data: bit 8 bootstrap (ignored), bit 10 extended, bit 11 enable, bits 35:12 base |
| ext_supported | input | 1 | The extended mode is available |
| init_id | input | 32 | Initial physical identifier of the agent |
| mode | output | 2 | Current mode: 0 off, 1 legacy, 2 extended |
| base_addr | output | 24 | Base address field |
| bootstrap | output | 1 | Bootstrap-processor flag |
| wr_err | output | 1 | One-cycle pulse after a rejected write |
| ext_lid | output | 32 | Derived extended logical identifier |
| sw_en_clear | output | 1 | One-cycle pulse to clear the software-enable bit of the priority core |

## Verification
The embedded assertions check several properties on every cycle. The off mode never steps straight to extended, and the extended mode never falls back to legacy. Extended mode is never entered while the feature is absent. An error pulse always comes with unchanged state. The clear pulse only appears with the mode off, and never together with the error pulse. While extended, the low half of the logical identifier is one-hot. Only the bench's scenarios can show the remaining behaviour: the exact identifier value for chosen physical IDs, the base field being loaded from the data, the bootstrap flag ignoring writes, the reset values, and the fact that each pulse lasts one cycle only.

// File: rtl/lic_mode_pkg.sv
package lic_mode_pkg;

    localparam int BOOT_BIT = 8;
    localparam int EXT_BIT  = 10;
    localparam int EN_BIT   = 11;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_LEGACY = 2'd1,
        MODE_EXT    = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        REJ_NONE,
        REJ_NO_FEATURE,
        REJ_EXT_NO_EN,
        REJ_SKIP_LEGACY,
        REJ_EXT_TO_LEGACY
    } reject_e;

    typedef struct packed {
        logic en;
        logic ext;
    } mode_req_t;

    // Mode that a write asks for, before the legality check.
    function automatic mode_e requested_mode(mode_req_t r);
        if (!r.en)
            return MODE_OFF;
        else if (r.ext)
            return MODE_EXT;
        else
            return MODE_LEGACY;
    endfunction

endpackage

// File: rtl/lic_transition_guard.sv
module lic_transition_guard
    import lic_mode_pkg::*;
(
    input  mode_e     cur_mode,
    input  mode_req_t req,
    input  logic      ext_supported,
    output mode_e     next_mode,
    output reject_e   reason,
    output logic      accept,
    output logic      disabling
);

    always_comb begin
        reason = REJ_NONE;
        if (req.ext && !ext_supported)
            reason = REJ_NO_FEATURE;
        else if (req.ext && !req.en)
            reason = REJ_EXT_NO_EN;
        else if (cur_mode == MODE_OFF && req.en && req.ext)
            reason = REJ_SKIP_LEGACY;
        else if (cur_mode == MODE_EXT && req.en && !req.ext)
            reason = REJ_EXT_TO_LEGACY;
    end

    assign next_mode = requested_mode(req);
    assign accept    = (reason == REJ_NONE);
    assign disabling = accept && !req.en;

endmodule

// File: rtl/lic_lid_derive.sv
module lic_lid_derive #(
    parameter int ID_W      = 32,
    parameter int SLOT_W    = 4,
    parameter int CLUSTER_W = 16,
    localparam int SLOTS    = 1 << SLOT_W,
    localparam int LID_W    = CLUSTER_W + SLOTS
) (
    input  logic [ID_W-1:0]  phys_id,
    output logic [LID_W-1:0] lid
);

    logic [SLOTS-1:0] slot_onehot;
    logic             unused_id;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign slot_onehot[s] = (phys_id[SLOT_W-1:0] == SLOT_W'(s));
    end

    assign lid       = {phys_id[SLOT_W+CLUSTER_W-1:SLOT_W], slot_onehot};
    assign unused_id = ^phys_id;

endmodule

// File: rtl/lic_mode_ctrl.sv
module lic_mode_ctrl
    import lic_mode_pkg::*;
#(
    parameter int          DATA_W     = 64,
    parameter int          ID_W       = 32,
    parameter int          BASE_LSB   = 12,
    parameter int          BASE_W     = 24,
    parameter int unsigned BASE_RESET = 32'h000F_EE00,
    parameter bit          BOOT_RESET = 1'b1,
    parameter int          SLOT_W     = 4,
    parameter int          CLUSTER_W  = 16,
    localparam int         SLOTS      = 1 << SLOT_W,
    localparam int         LID_W      = CLUSTER_W + SLOTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ext_supported,
    input  logic [ID_W-1:0]   init_id,
    output logic [1:0]        mode,
    output logic [BASE_W-1:0] base_addr,
    output logic              bootstrap,
    output logic              wr_err,
    output logic [LID_W-1:0]  ext_lid,
    output logic              sw_en_clear
);

    mode_e             mode_q;
    logic [BASE_W-1:0] base_q;
    logic              boot_q;
    logic [LID_W-1:0]  lid_q;
    logic              err_q;
    logic              clr_q;

    mode_req_t         req;
    mode_e             next_mode;
    reject_e           reason;
    logic              accept;
    logic              disabling;
    logic [LID_W-1:0]  lid_new;
    logic              unused_wr;

    assign req.en    = wr_data[EN_BIT];
    assign req.ext   = wr_data[EXT_BIT];
    assign unused_wr = ^{wr_data, reason};

    lic_transition_guard u_guard (
        .cur_mode      (mode_q),
        .req           (req),
        .ext_supported (ext_supported),
        .next_mode     (next_mode),
        .reason        (reason),
        .accept        (accept),
        .disabling     (disabling)
    );

    lic_lid_derive #(
        .ID_W      (ID_W),
        .SLOT_W    (SLOT_W),
        .CLUSTER_W (CLUSTER_W)
    ) u_lid (
        .phys_id (init_id),
        .lid     (lid_new)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_LEGACY;
            base_q <= BASE_W'(BASE_RESET);
            boot_q <= BOOT_RESET;
            lid_q  <= '0;
            err_q  <= 1'b0;
            clr_q  <= 1'b0;
        end else begin
            err_q <= wr_en && !accept;
            clr_q <= wr_en && disabling;
            if (wr_en && accept) begin
                mode_q <= next_mode;
                base_q <= wr_data[BASE_LSB +: BASE_W];
                if (next_mode == MODE_EXT)
                    lid_q <= lid_new;
            end
        end
    end

    assign mode        = mode_q;
    assign base_addr   = base_q;
    assign bootstrap   = boot_q;
    assign wr_err      = err_q;
    assign ext_lid     = lid_q;
    assign sw_en_clear = clr_q;

    // R1: without the feature, extended mode cannot be entered
    a_r1_no_ext_without_feature: assert property (@(posedge clk) disable iff (rst)
        (!ext_supported && mode_q != MODE_EXT) |=> (mode_q != MODE_EXT));

    // R3: off never goes straight to extended
    a_r3_no_skip_legacy: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_OFF) |=> (mode_q != MODE_EXT));

    // R4: extended never falls back to legacy
    a_r4_no_ext_to_legacy: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_EXT) |=> (mode_q != MODE_LEGACY));

    // R5: the clear pulse only comes with the controller off
    a_r5_clear_means_off: assert property (@(posedge clk) disable iff (rst)
        sw_en_clear |-> (mode_q == MODE_OFF));

    // R6: extended logical identifier carries a one-hot slot
    a_r6_slot_onehot: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_EXT) |-> ($countones(lid_q[SLOTS-1:0]) == 1));

    // R8: a rejected write changes no state
    a_r8_reject_holds: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> (mode_q == $past(mode_q) && base_q == $past(base_q)
                    && lid_q == $past(lid_q) && boot_q == $past(boot_q)));

    // R8: error and clear pulses never coincide
    a_r8_err_not_clear: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> !sw_en_clear);

endmodule

// File: tb/test_lic_mode_ctrl.sv
`timescale 1ns/1ps
module test_lic_mode_ctrl;

    typedef struct packed {
        logic [1:0]  mode;
        logic [23:0] base;
        logic        boot;
        logic        err;
        logic        clr;
        logic [31:0] lid;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        ext_supported = 1'b1;
    logic [31:0] init_id = 32'h0001_2345;
    logic [1:0]  mode;
    logic [23:0] base_addr;
    logic        bootstrap;
    logic        wr_err;
    logic [31:0] ext_lid;
    logic        sw_en_clear;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    exp_t  exp_q[$];
    string tag_q[$];

    // bench model of the register
    logic [1:0]  m_mode = 2'd1;
    logic [23:0] m_base = 24'h0FEE00;
    logic [31:0] m_lid  = 32'h0;

    always #5 clk = ~clk;

    lic_mode_ctrl i_lic_mode_ctrl (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .ext_supported (ext_supported),
        .init_id       (init_id),
        .mode          (mode),
        .base_addr     (base_addr),
        .bootstrap     (bootstrap),
        .wr_err        (wr_err),
        .ext_lid       (ext_lid),
        .sw_en_clear   (sw_en_clear)
    );

    function automatic logic [63:0] mk(input logic en, input logic ext,
                                       input logic boot, input logic [23:0] base);
        return {28'h0, base, en, ext, 1'b0, boot, 8'h5A};
    endfunction

    task automatic compare(input exp_t e, input string tag);
        exp_t got;
        got = '{mode: mode, base: base_addr, boot: bootstrap, err: wr_err,
                clr: sw_en_clear, lid: ext_lid};
        checks++;
        if (got !== e) begin
            errors++;
            $display("FAIL %s: got mode=%0d base=%h boot=%b err=%b clr=%b lid=%h, expected mode=%0d base=%h boot=%b err=%b clr=%b lid=%h",
                     tag, got.mode, got.base, got.boot, got.err, got.clr, got.lid,
                     e.mode, e.base, e.boot, e.err, e.clr, e.lid);
        end
    endtask

    task automatic do_write(input logic [63:0] d, input string tag);
        logic en, ex, bad;
        exp_t e;
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        en = d[11];
        ex = d[10];
        bad = 1'b0;
        if (ex && !ext_supported)      bad = 1'b1;
        if (ex && !en)                 bad = 1'b1;
        if (m_mode == 2'd0 && en && ex) bad = 1'b1;
        if (m_mode == 2'd2 && en && !ex) bad = 1'b1;
        if (!bad) begin
            m_mode = !en ? 2'd0 : (ex ? 2'd2 : 2'd1);
            m_base = d[35:12];
            if (m_mode == 2'd2)
                m_lid = ({16'h0, init_id[19:4]} << 16) | (32'h1 << init_id[3:0]);
        end
        e = '{mode: m_mode, base: m_base, boot: 1'b1, err: bad,
              clr: (!bad && !en), lid: m_lid};
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        wr_en = 1'b0;
        e.err = 1'b0;
        e.clr = 1'b0;
        exp_q.push_back(e);
        tag_q.push_back({tag, " (pulse ends)"});
    endtask

    // monitor: compares one queued item per cycle, just after the edge
    initial begin
        exp_t  e;
        string t;
        @(negedge rst);
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                compare(e, t);
            end
        end
    end

    initial begin
        repeat (3000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        compare('{mode: 2'd1, base: 24'h0FEE00, boot: 1'b1, err: 1'b0,
                  clr: 1'b0, lid: 32'h0}, "R9 reset state");

        do_write(mk(1'b0, 1'b1, 1'b0, 24'h111111), "R2 ext without enable rejected");
        do_write(mk(1'b1, 1'b0, 1'b0, 24'h222222), "R10 legacy to legacy, R7 base load");
        do_write(mk(1'b1, 1'b1, 1'b0, 24'hABCDE0), "R6 legacy to extended, lid derived, R7 boot kept");
        do_write(mk(1'b1, 1'b0, 1'b1, 24'h333333), "R4 extended to legacy rejected");
        do_write(mk(1'b1, 1'b1, 1'b1, 24'h444444), "R10 extended to extended, R7 boot ignores write");
        do_write(mk(1'b0, 1'b0, 1'b0, 24'h555555), "R5 extended to off with clear pulse");
        do_write(mk(1'b1, 1'b1, 1'b0, 24'h666666), "R3 off to extended rejected");
        do_write(mk(1'b0, 1'b0, 1'b0, 24'h777777), "R5 off to off still pulses clear");
        do_write(mk(1'b1, 1'b0, 1'b0, 24'h0FEE00), "R10 off to legacy");
        ext_supported = 1'b0;
        do_write(mk(1'b1, 1'b1, 1'b0, 24'h888888), "R1 extended without feature rejected");
        do_write(mk(1'b0, 1'b1, 1'b0, 24'h999999), "R8 second reject keeps state");
        ext_supported = 1'b1;
        init_id = 32'hABCF_FFFF;
        do_write(mk(1'b1, 1'b1, 1'b0, 24'h123456), "R6 top slot and full cluster");
        init_id = 32'h0000_0010;
        do_write(mk(1'b1, 1'b1, 1'b0, 24'h654321), "R6 re-derived on extended rewrite, slot 0");
        do_write(mk(1'b0, 1'b0, 1'b0, 24'h000001), "R5 disable from extended again");

        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10: got %0d unchecked items, expected 0", exp_q.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule